// File: doc/BRIEF.md
# Tournament Branch Predictor

This block predicts the direction of conditional branches by running two predictors side by side and letting a third table decide, per branch, which of the two to trust. The first predictor looks only at the global path: a shift register holding the outcomes of the most recent branches addresses a table of 2-bit saturating counters. The second predictor works per branch in two levels. A table indexed by branch address keeps the recent outcome history of that one branch. That history then addresses a table of 3-bit saturating counters. A per-address table of 2-bit selector counters picks the final answer.

Predictions are purely combinational from the `pred_addr` input. The final answer comes out, and so do both component predictions and the selector's choice. A resolved branch is reported on the update port. In a single clock edge, the update trains the global counter, the local counter and the selector entry of that branch. It then shifts the outcome into the global history and into that branch's local history. The update uses the entries that a prediction for the same address reads in that same cycle. When no other update falls between the prediction and the resolution of a branch, these are the entries the prediction used. All table sizes are parameters.

Top module: `tp_tournament`

## Requirements
- R1: After reset, all histories and all global and local counters are zero and every selector counter holds 01. For any address, all of `pred_taken`, `pred_global`, `pred_local` and `pred_use_global` read 0.
- R2: `pred_global` is 1 exactly when the 2-bit counter addressed by the global history holds 2 or 3.
- R3: `pred_local` is 1 exactly when the 3-bit counter holds 4 or more. That counter is addressed by the local history stored for the branch's address.
- R4: `pred_use_global` is the MSB of the selector counter for the address: 1 picks the global prediction and 0 the local one. `pred_taken` equals the picked prediction.
- R5: On an update, the selector counter steps up by one if only the global prediction was correct. It steps down by one if only the local prediction was correct. Otherwise it is unchanged. It saturates at 0 and 3.
- R6: On an update, the addressed global and local counters step up on a taken outcome and down on a not-taken outcome. They saturate at 0 and 3 (global) and at 0 and 7 (local).
- R7: On an update, the outcome (taken = 1) enters bit 0 of the global history and bit 0 of the addressed local history, and older bits move up one place. Other local history entries keep their values.
- R8: While `upd_valid` is 0, no table or history changes, whatever the other update inputs do.
- R9: A prediction made in the same cycle as an update reflects the state before that update. The effect of the update is visible from the following cycle.
- R10: Table indices come from the address bits starting at bit `ADDR_LSB`. Address bits below that position have no effect on prediction or update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pred_addr | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_global | output | 1 | Prediction of the global-history predictor |
| pred_local | output | 1 | Prediction of the per-branch two-level predictor |
| pred_use_global | output | 1 | Selector choice (1 = global, 0 = local) |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction (1 = taken) |

## Verification
A prediction lookup and a training update can fall in the same cycle, on the same address or on different ones. The update then rewrites the very entries and history bits that the lookup reads. The bench provokes this by presenting an address on the predict port together with a valid update of that same address. It samples the outputs before the clock edge and compares them with a bench model still in its pre-update state. After the edge, it compares them with the model in its post-update state. The selector's only-one-correct rule is also judged by the checker on every update.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // next value of a 2-bit saturating counter
  function automatic logic [1:0] ctr2_next(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // next value of a 3-bit saturating counter
  function automatic logic [2:0] ctr3_next(input logic [2:0] c, input logic up);
    if (up) return (c == 3'd7) ? c : c + 3'd1;
    return (c == 3'd0) ? c : c - 3'd1;
  endfunction

  function automatic logic ctr2_taken(input logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic ctr3_taken(input logic [2:0] c);
    return c[2];
  endfunction

endpackage

// File: rtl/tp_global_pred.sv
module tp_global_pred #(
  parameter int GHIST_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_valid,
  input  logic               upd_taken,
  output logic               pred_taken,
  output logic [GHIST_W-1:0] hist_q,
  output logic [1:0]         cur_ctr,
  output logic [1:0]         nxt_ctr
);
  import tp_pkg::*;

  localparam int ENTRIES = 1 << GHIST_W;

  logic [1:0] ctr_q [ENTRIES];

  // the global path history is the only index, for predict and update alike
  assign cur_ctr    = ctr_q[hist_q];
  assign nxt_ctr    = ctr2_next(cur_ctr, upd_taken);
  assign pred_taken = ctr2_taken(cur_ctr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= '0;
    end else if (upd_valid) begin
      ctr_q[hist_q] <= nxt_ctr;
      hist_q        <= {hist_q[GHIST_W-2:0], upd_taken};
    end
  end

endmodule

// File: rtl/tp_local_pred.sv
module tp_local_pred #(
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LHT_IDX_W-1:0] pred_idx,
  input  logic [LHT_IDX_W-1:0] upd_idx,
  input  logic                 upd_valid,
  input  logic                 upd_taken,
  output logic                 pred_taken,
  output logic [LHIST_W-1:0]   upd_hist,
  output logic [2:0]           cur_ctr,
  output logic [2:0]           nxt_ctr
);
  import tp_pkg::*;

  localparam int LHT_N = 1 << LHT_IDX_W;
  localparam int LCT_N = 1 << LHIST_W;

  logic [LHIST_W-1:0] lht_q [LHT_N];
  logic [2:0]         lct_q [LCT_N];
  logic [LHIST_W-1:0] pred_hist;

  // first level: per-branch history; second level: counters addressed by it
  assign pred_hist  = lht_q[pred_idx];
  assign pred_taken = ctr3_taken(lct_q[pred_hist]);

  assign upd_hist = lht_q[upd_idx];
  assign cur_ctr  = lct_q[upd_hist];
  assign nxt_ctr  = ctr3_next(cur_ctr, upd_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LHT_N; i++) lht_q[i] <= '0;
      for (int j = 0; j < LCT_N; j++) lct_q[j] <= '0;
    end else if (upd_valid) begin
      lct_q[upd_hist] <= nxt_ctr;
      lht_q[upd_idx]  <= {upd_hist[LHIST_W-2:0], upd_taken};
    end
  end

endmodule

// File: rtl/tp_chooser.sv
module tp_chooser #(
  parameter int CH_IDX_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CH_IDX_W-1:0] pred_idx,
  input  logic [CH_IDX_W-1:0] upd_idx,
  input  logic                upd_valid,
  input  logic                global_ok,
  input  logic                local_ok,
  output logic                use_global,
  output logic [1:0]          cur_sel,
  output logic [1:0]          nxt_sel
);
  import tp_pkg::*;

  localparam int ENTRIES = 1 << CH_IDX_W;
  localparam logic [1:0] SEL_RESET = 2'b01;  // weakly prefer local

  logic [1:0] sel_q [ENTRIES];
  logic       one_right;

  assign use_global = sel_q[pred_idx][1];
  assign cur_sel    = sel_q[upd_idx];
  assign one_right  = global_ok ^ local_ok;
  assign nxt_sel    = one_right ? ctr2_next(cur_sel, global_ok) : cur_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) sel_q[i] <= SEL_RESET;
    end else if (upd_valid) begin
      sel_q[upd_idx] <= nxt_sel;
    end
  end

endmodule

// File: rtl/tp_tournament.sv
module tp_tournament #(
  parameter int ADDR_W    = 32,
  parameter int ADDR_LSB  = 2,
  parameter int CH_IDX_W  = 12,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              pred_taken,
  output logic              pred_global,
  output logic              pred_local,
  output logic              pred_use_global,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);

  logic [CH_IDX_W-1:0]  ch_pred_idx, ch_upd_idx;
  logic [LHT_IDX_W-1:0] lh_pred_idx, lh_upd_idx;

  // named internal events, brought out for the checker
  logic [GHIST_W-1:0] ghist_q;
  logic [LHIST_W-1:0] lhist_upd;
  logic [1:0]         g_cur, g_nxt, ch_cur, ch_nxt;
  logic [2:0]         l_cur, l_nxt;
  logic               g_ok, l_ok;

  wire unused_addr_bits = ^{pred_addr, upd_addr, lhist_upd};

  assign ch_pred_idx = pred_addr[ADDR_LSB +: CH_IDX_W];
  assign ch_upd_idx  = upd_addr[ADDR_LSB +: CH_IDX_W];
  assign lh_pred_idx = pred_addr[ADDR_LSB +: LHT_IDX_W];
  assign lh_upd_idx  = upd_addr[ADDR_LSB +: LHT_IDX_W];

  tp_global_pred #(.GHIST_W(GHIST_W)) glob_i (
    .clk        (clk),
    .rst        (rst),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .pred_taken (pred_global),
    .hist_q     (ghist_q),
    .cur_ctr    (g_cur),
    .nxt_ctr    (g_nxt)
  );

  tp_local_pred #(.LHT_IDX_W(LHT_IDX_W), .LHIST_W(LHIST_W)) loc_i (
    .clk        (clk),
    .rst        (rst),
    .pred_idx   (lh_pred_idx),
    .upd_idx    (lh_upd_idx),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .pred_taken (pred_local),
    .upd_hist   (lhist_upd),
    .cur_ctr    (l_cur),
    .nxt_ctr    (l_nxt)
  );

  // each component was right when its update-time prediction matches the outcome
  assign g_ok = (g_cur[1] == upd_taken);
  assign l_ok = (l_cur[2] == upd_taken);

  tp_chooser #(.CH_IDX_W(CH_IDX_W)) sel_i (
    .clk        (clk),
    .rst        (rst),
    .pred_idx   (ch_pred_idx),
    .upd_idx    (ch_upd_idx),
    .upd_valid  (upd_valid),
    .global_ok  (g_ok),
    .local_ok   (l_ok),
    .use_global (pred_use_global),
    .cur_sel    (ch_cur),
    .nxt_sel    (ch_nxt)
  );

  assign pred_taken = pred_use_global ? pred_global : pred_local;

endmodule

// File: rtl/tp_tournament_chk.sv
module tp_tournament_chk #(
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [GHIST_W-1:0] ghist_q,
  input logic [1:0]         g_cur,
  input logic [1:0]         g_nxt,
  input logic [2:0]         l_cur,
  input logic [2:0]         l_nxt,
  input logic [1:0]         ch_cur,
  input logic [1:0]         ch_nxt
);

  logic glob_right, loc_right;
  assign glob_right = g_cur[1] == upd_taken;
  assign loc_right  = l_cur[2] == upd_taken;

  // R7
  ghist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghist_q == {$past(ghist_q[GHIST_W-2:0]), $past(upd_taken)});

  // R8
  ghist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghist_q));

  // R5
  ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (glob_right == loc_right)) |-> ch_nxt == ch_cur);

  // R5
  ch_to_global_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && glob_right && !loc_right && ch_cur != 2'd3) |-> ch_nxt == ch_cur + 2'd1);

  // R5
  ch_to_local_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !glob_right && loc_right && ch_cur != 2'd0) |-> ch_nxt == ch_cur - 2'd1);

  // R6
  g_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && g_cur == 2'd3) |-> g_nxt == 2'd3);

  // R6
  l_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && l_cur == 3'd0) |-> l_nxt == 3'd0);

  // R6
  l_step_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && l_cur != 3'd7) |-> l_nxt == l_cur + 3'd1);

endmodule

bind tp_tournament tp_tournament_chk #(.GHIST_W(GHIST_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .ghist_q   (ghist_q),
  .g_cur     (g_cur),
  .g_nxt     (g_nxt),
  .l_cur     (l_cur),
  .l_nxt     (l_nxt),
  .ch_cur    (ch_cur),
  .ch_nxt    (ch_nxt)
);

// File: tb/tp_tournament_tb.sv
`timescale 1ns/1ps
module tp_tournament_tb_top;

  localparam int AW  = 12;
  localparam int LSB = 2;
  localparam int CW  = 4;
  localparam int GW  = 4;
  localparam int LIW = 3;
  localparam int LHW = 3;
  localparam int CN  = 1 << CW;
  localparam int GN  = 1 << GW;
  localparam int LIN = 1 << LIW;
  localparam int LCN = 1 << LHW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] pred_addr = '0;
  logic          pred_taken, pred_global, pred_local, pred_use_global;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_addr = '0;
  logic          upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tp_tournament #(
    .ADDR_W(AW), .ADDR_LSB(LSB), .CH_IDX_W(CW),
    .GHIST_W(GW), .LHT_IDX_W(LIW), .LHIST_W(LHW)
  ) dut_i (
    .clk(clk), .rst(rst), .pred_addr(pred_addr),
    .pred_taken(pred_taken), .pred_global(pred_global),
    .pred_local(pred_local), .pred_use_global(pred_use_global),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken)
  );

  // ---------------- bench model, written from the requirements ----------------
  int m_gh;
  int m_gc [GN];
  int m_lh [LIN];
  int m_lc [LCN];
  int m_ch [CN];

  function automatic int sel_ix(int a);  return (a >> LSB) % CN;  endfunction
  function automatic int hist_ix(int a); return (a >> LSB) % LIN; endfunction

  function automatic bit m_glob();       return m_gc[m_gh] > 1; endfunction
  function automatic bit m_loc(int a);   return m_lc[m_lh[hist_ix(a)]] > 3; endfunction
  function automatic bit m_useg(int a);  return m_ch[sel_ix(a)] > 1; endfunction
  function automatic bit m_final(int a); return m_useg(a) ? m_glob() : m_loc(a); endfunction

  function automatic int clamp(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic model_reset();
    m_gh = 0;
    foreach (m_gc[i]) m_gc[i] = 0;
    foreach (m_lh[i]) m_lh[i] = 0;
    foreach (m_lc[i]) m_lc[i] = 0;
    foreach (m_ch[i]) m_ch[i] = 1;
  endtask

  task automatic model_update(int a, bit t);
    int  step = t ? 1 : -1;
    bit  gr   = (m_glob() == t);
    bit  lr   = (m_loc(a) == t);
    int  h    = m_lh[hist_ix(a)];
    m_gc[m_gh] = clamp(m_gc[m_gh] + step, 3);
    m_lc[h]    = clamp(m_lc[h] + step, 7);
    if (gr && !lr) m_ch[sel_ix(a)] = clamp(m_ch[sel_ix(a)] + 1, 3);
    if (lr && !gr) m_ch[sel_ix(a)] = clamp(m_ch[sel_ix(a)] - 1, 3);
    m_gh = ((m_gh * 2) + int'(t)) % GN;
    m_lh[hist_ix(a)] = ((h * 2) + int'(t)) % LCN;
  endtask

  // ---------------- checking helpers ----------------
  task automatic check_bit(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  // compare all four outputs for one address against the model; we are between edges
  task automatic check_addr(int a, string ctx);
    pred_addr = AW'(a);
    #0.5;
    check_bit("R2", {ctx, " global"}, pred_global, m_glob());
    check_bit("R3", {ctx, " local"},  pred_local,  m_loc(a));
    check_bit("R4", {ctx, " select"}, pred_use_global, m_useg(a));
    check_bit("R4", {ctx, " final"},  pred_taken, m_final(a));
  endtask

  task automatic sweep(string ctx);
    for (int k = 0; k < CN; k++) check_addr(k << LSB, ctx);
  endtask

  task automatic update(int a, bit t);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_addr  = AW'(a);
    upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
    model_update(a, t);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();  // R1
    for (int k = 0; k < CN; k++) begin
      pred_addr = AW'(k << LSB);
      #0.5;
      check_bit("R1", "reset taken",  pred_taken, 1'b0);
      check_bit("R1", "reset global", pred_global, 1'b0);
      check_bit("R1", "reset local",  pred_local, 1'b0);
      check_bit("R1", "reset select", pred_use_global, 1'b0);
    end
  endtask

  task automatic t_loop();  // R2 R3 R6 R7: inner-loop exit pattern
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < 5; i++) begin
        update(8'h40, i != 4);
        check_addr(8'h40, "loop");
        check_addr(8'h44, "loop other");
      end
    sweep("loop sweep R7");
  endtask

  task automatic t_correlated();  // R5: selector driven by correlated branches
    for (int r = 0; r < 24; r++) begin
      bit a_out = (r % 3) != 0;
      update(8'h10, a_out);
      check_addr(8'h10, "corr R5 a");
      update(8'h14, (r % 2) == 0);
      update(8'h18, a_out);
      check_addr(8'h18, "corr R5 c");
    end
    sweep("corr sweep R5");
  endtask

  task automatic t_saturate();  // R6: long runs both ways
    for (int i = 0; i < 20; i++) begin
      update(8'h24, 1'b1);
      check_addr(8'h24, "sat up R6");
    end
    for (int i = 0; i < 20; i++) begin
      update(8'h24, 1'b0);
      check_addr(8'h24, "sat down R6");
    end
    sweep("sat sweep R6");
  endtask

  task automatic t_idle();  // R8
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      upd_valid = 1'b0;
      upd_addr  = AW'(i << LSB);
      upd_taken = i[0];
    end
    @(negedge clk);
    sweep("idle R8");
  endtask

  task automatic t_same_cycle();  // R9
    for (int i = 0; i < 6; i++) begin
      int a = (i % 2 == 0) ? 8'h30 : 8'h34;
      bit t = (i % 3) != 1;
      @(negedge clk);
      pred_addr = AW'(a);
      upd_valid = 1'b1;
      upd_addr  = AW'(a);
      upd_taken = t;
      #0.5;
      check_bit("R9", "pre global", pred_global, m_glob());
      check_bit("R9", "pre local",  pred_local,  m_loc(a));
      check_bit("R9", "pre final",  pred_taken,  m_final(a));
      @(negedge clk);
      upd_valid = 1'b0;
      model_update(a, t);
      check_addr(a, "post R9");
    end
  endtask

  task automatic t_alias();  // R10: low address bits ignored
    for (int i = 0; i < 6; i++) begin
      update(8'h28 | (i % 4), 1'b1);
      check_addr(8'h28 | ((i + 1) % 4), "alias R10");
      check_addr(8'h28, "alias base R10");
    end
    sweep("alias sweep R10");
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_loop();
    t_correlated();
    t_saturate();
    t_idle();
    t_same_cycle();
    t_alias();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule